// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns a memory mode word and a starting column into the stream of column addresses that one burst of a synchronous DRAM access visits. A start strobe loads the column together with the mode word and the access direction. From the next cycle on, the block presents one column per beat and raises a last-beat flag on the final beat. A per-beat advance input moves it to the next column, and while that input is low the current beat is held.

The burst length can be 1, 2, 4 or 8 columns, or a whole row. Short bursts visit an aligned block of columns, either by counting up with wrap-around or by XOR-ing the beat number into the start column. A whole-row burst counts up modulo the row size and runs until a terminate input stops it. A start that arrives during a burst discards the rest of that burst and begins a new one at full length. Mode words with reserved codes raise an error flag and fall back to single-beat bursts.

Top module: `burst_col_gen`

## Requirements
- R1: The mode word is sampled only on the cycle `startValid` is high. Its bits [2:0] choose the burst length: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8, and 111 gives a whole row of 256 columns.
- R2: The cycle after a start, `colValid` is high and `colOut` equals the start column (beat 0).
- R3: With mode bit 3 at 0 (counting order) and a burst length BL of 2, 4 or 8, beat k keeps the column bits above log2(BL) from the start column. Its low log2(BL) bits are (start + k) mod BL, so no carry passes into the upper bits.
- R4: With mode bit 3 at 1 (XOR order) and BL of 2, 4 or 8, beat k keeps the same upper bits as the start column, and its low log2(BL) bits are the start's low bits XOR k.
- R5: A beat moves on only in a cycle with `beatEn` high. Otherwise `colOut`, `colValid` and `lastBeat` hold.
- R6: `lastBeat` is high exactly while beat BL-1 of a non-row burst is shown. Advancing from that beat drops `colValid` in the next cycle.
- R7: A whole-row burst shows (start + k) mod 256 on beat k, whatever bit 3 is. It never raises `lastBeat`. A `stopReq` during the burst drops `colValid` in the next cycle.
- R8: `stopReq` has no effect on bursts of length 1, 2, 4 or 8.
- R9: A start during a burst abandons the remaining beats and begins a new burst of full length at the new column.
- R10: When mode bit 9 is 1 and `isWrite` is high at the start, the burst length is 1. For a read with the same mode word, the coded length applies.
- R11: `modeErr` is loaded at each start and held until the next start. It is set when bits [2:0] are 100, 101 or 110, when bits [6:4] are neither 010 nor 011, or when bits [8:7] are not 00. An erroneous burst has length 1.
- R12: After reset, `colValid`, `lastBeat` and `modeErr` are 0 and `colOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| startValid | input | 1 | Start a new burst this cycle |
| startCol | input | 8 | First column of the burst |
| modeWord | input | 10 | Mode word, sampled with the start |
| isWrite | input | 1 | The access being started is a write |
| beatEn | input | 1 | Advance to the next beat |
| stopReq | input | 1 | Terminate a whole-row burst |
| colOut | output | 8 | Column address of the current beat |
| colValid | output | 1 | A burst beat is being presented |
| lastBeat | output | 1 | Current beat is the final one |
| modeErr | output | 1 | Last sampled mode word held a reserved code |

## Verification
The properties take for granted that the inputs are known, two-state values on every clock edge after reset, and that a start may arrive in any cycle, with or without `beatEn` or `stopReq`. They make no assumption about which mode codes arrive. Reserved codes are legal stimulus and must produce the single-beat fallback. The random stimulus draws every field of the mode word, including reserved values, and sets start, advance and terminate independently. Start is kept rare enough that bursts of length eight and whole-row wrap-around run to completion.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  localparam int BL_LSB  = 0;
  localparam int BL_W    = 3;
  localparam int ILV_BIT = 3;
  localparam int CL_LSB  = 4;
  localparam int CL_W    = 3;
  localparam int OPM_LSB = 7;
  localparam int OPM_W   = 2;
  localparam int WB_BIT  = 9;

  localparam logic [BL_W-1:0] BL_ONE  = 3'b000;
  localparam logic [BL_W-1:0] BL_TWO  = 3'b001;
  localparam logic [BL_W-1:0] BL_FOUR = 3'b010;
  localparam logic [BL_W-1:0] BL_EIGHT = 3'b011;
  localparam logic [BL_W-1:0] BL_ROW  = 3'b111;
  localparam logic [CL_W-1:0] CL_TWO  = 3'b010;
  localparam logic [CL_W-1:0] CL_THREE = 3'b011;

  typedef struct packed {
    logic load;
    logic step;
    logic ilv;
  } bcgStrobe_t;
endpackage

// File: rtl/bcg_ctrl.sv
module bcg_ctrl
  import bcg_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int MODE_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [MODE_W-1:0] modeWord,
  input  logic              isWrite,
  input  logic              beatEn,
  input  logic              stopReq,
  input  logic              atLast,
  output bcgStrobe_t        strobe,
  output logic [COL_W-1:0]  loadMask,
  output logic              colValid,
  output logic              lastBeat,
  output logic              modeErr
);
  localparam int LOG_W = $clog2(COL_W + 1);

  logic [BL_W-1:0]  blCode;
  logic [CL_W-1:0]  clCode;
  logic [OPM_W-1:0] opCode;
  logic             blRes, clRes, opRes, errNow, singleNow, rowNow;
  logic [LOG_W-1:0] lenLog;
  logic             busyR, rowR, errR;

  assign blCode = modeWord[BL_LSB +: BL_W];
  assign clCode = modeWord[CL_LSB +: CL_W];
  assign opCode = modeWord[OPM_LSB +: OPM_W];

  always_comb begin
    blRes     = !(blCode == BL_ONE || blCode == BL_TWO || blCode == BL_FOUR ||
                  blCode == BL_EIGHT || blCode == BL_ROW);
    clRes     = !(clCode == CL_TWO || clCode == CL_THREE);
    opRes     = (opCode != '0);
    errNow    = blRes | clRes | opRes;
    singleNow = modeWord[WB_BIT] & isWrite;
    rowNow    = (blCode == BL_ROW) && !errNow && !singleNow;
    case (blCode)
      BL_TWO:   lenLog = LOG_W'(1);
      BL_FOUR:  lenLog = LOG_W'(2);
      BL_EIGHT: lenLog = LOG_W'(3);
      default:  lenLog = '0;
    endcase
    if (errNow || singleNow) lenLog = '0;
  end

  generate
    for (genvar i = 0; i < COL_W; i++) begin : g_mask
      assign loadMask[i] = rowNow || (LOG_W'(i) < lenLog);
    end
  endgenerate

  assign lastBeat    = busyR && !rowR && atLast;
  assign strobe.load = startValid;
  assign strobe.ilv  = modeWord[ILV_BIT] && !rowNow;
  assign strobe.step = !startValid && busyR && beatEn && !lastBeat && !(rowR && stopReq);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyR <= 1'b0;
      rowR  <= 1'b0;
      errR  <= 1'b0;
    end else if (startValid) begin
      busyR <= 1'b1;
      rowR  <= rowNow;
      errR  <= errNow;
    end else if (busyR) begin
      if (rowR && stopReq)          busyR <= 1'b0;
      else if (beatEn && lastBeat)  busyR <= 1'b0;
    end
  end

  assign colValid = busyR;
  assign modeErr  = errR;
endmodule

// File: rtl/bcg_dp.sv
module bcg_dp
  import bcg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  bcgStrobe_t       strobe,
  input  logic [COL_W-1:0] loadMask,
  input  logic [COL_W-1:0] startCol,
  output logic [COL_W-1:0] colOut,
  output logic             atLast
);
  logic [COL_W-1:0] baseR, beatR, maskR, sumCol;
  logic             ilvR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseR <= '0;
      beatR <= '0;
      maskR <= '0;
      ilvR  <= 1'b0;
    end else if (strobe.load) begin
      baseR <= startCol;
      beatR <= '0;
      maskR <= loadMask;
      ilvR  <= strobe.ilv;
    end else if (strobe.step) begin
      beatR <= beatR + 1'b1;
    end
  end

  assign sumCol = baseR + beatR;
  assign atLast = (beatR == maskR);

  generate
    for (genvar i = 0; i < COL_W; i++) begin : g_col
      assign colOut[i] = !maskR[i] ? baseR[i]
                       : (ilvR ? (baseR[i] ^ beatR[i]) : sumCol[i]);
    end
  endgenerate
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int MODE_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [COL_W-1:0]  startCol,
  input  logic [MODE_W-1:0] modeWord,
  input  logic              isWrite,
  input  logic              beatEn,
  input  logic              stopReq,
  output logic [COL_W-1:0]  colOut,
  output logic              colValid,
  output logic              lastBeat,
  output logic              modeErr
);
  bcgStrobe_t       strobe;
  logic [COL_W-1:0] loadMask;
  logic             atLast;

  bcg_ctrl #(.COL_W(COL_W), .MODE_W(MODE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .modeWord(modeWord),
    .isWrite(isWrite), .beatEn(beatEn), .stopReq(stopReq), .atLast(atLast),
    .strobe(strobe), .loadMask(loadMask), .colValid(colValid),
    .lastBeat(lastBeat), .modeErr(modeErr)
  );

  bcg_dp #(.COL_W(COL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadMask(loadMask),
    .startCol(startCol), .colOut(colOut), .atLast(atLast)
  );
endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             startValid,
  input logic [COL_W-1:0] startCol,
  input logic             beatEn,
  input logic             stopReq,
  input logic [COL_W-1:0] colOut,
  input logic             colValid,
  input logic             lastBeat,
  input logic             modeErr
);
  // R2 and R9: any start shows its column as beat 0 next cycle
  p_first_beat_r2: assert property (@(posedge clk) disable iff (!rstN)
    startValid |=> (colValid && colOut == $past(startCol)));

  // R5: without advance, start or terminate the beat holds
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (colValid && !beatEn && !startValid && !stopReq) |=>
      (colValid && $stable(colOut) && $stable(lastBeat)));

  // R6: last flag only on a shown beat
  p_last_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |-> colValid);

  // R6: advancing from the last beat ends the burst
  p_last_end_r6: assert property (@(posedge clk) disable iff (!rstN)
    (lastBeat && beatEn && !startValid) |=> !colValid);

  // R11: an erroneous mode gives single-beat bursts
  p_err_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    (modeErr && colValid) |-> lastBeat);

  // R11: the error flag changes only with a start
  p_err_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !startValid |=> $stable(modeErr));

  // R12: nothing appears without a start
  p_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!colValid && !startValid) |=> !colValid);
endmodule

bind burst_col_gen bcg_checker #(.COL_W(COL_W)) u_bcg_checker (
  .clk(clk), .rstN(rstN), .startValid(startValid), .startCol(startCol),
  .beatEn(beatEn), .stopReq(stopReq), .colOut(colOut), .colValid(colValid),
  .lastBeat(lastBeat), .modeErr(modeErr)
);

// File: tb/burst_col_gen_bench.sv
module burst_col_gen_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startValid = 1'b0;
  logic [7:0] startCol = '0;
  logic [9:0] modeWord = '0;
  logic       isWrite = 1'b0;
  logic       beatEn = 1'b0;
  logic       stopReq = 1'b0;
  logic [7:0] colOut;
  logic       colValid, lastBeat, modeErr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // model state
  bit       mValid = 0, mRow = 0, mIlv = 0, mErr = 0;
  int       mBase = 0, mK = 0, mLen = 1;

  always #2.5 clk = ~clk;

  burst_col_gen u_burst_col_gen (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startCol(startCol),
    .modeWord(modeWord), .isWrite(isWrite), .beatEn(beatEn), .stopReq(stopReq),
    .colOut(colOut), .colValid(colValid), .lastBeat(lastBeat), .modeErr(modeErr)
  );

  function automatic logic [9:0] mkMode(int bl, int ilv, int cl, int opm, int wb);
    logic [9:0] m;
    m[2:0] = bl[2:0]; m[3] = ilv[0]; m[6:4] = cl[2:0]; m[8:7] = opm[1:0]; m[9] = wb[0];
    return m;
  endfunction

  function automatic int expCol(int base, int k, int len, bit ilv, bit row);
    int msk;
    if (row) return (base + k) % 256;
    msk = len - 1;
    if (ilv) return (base & ~msk & 255) | ((base ^ k) & msk);
    return (base & ~msk & 255) | ((base + k) & msk);
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic modelEdge();
    int blc, clc;
    bit err, single;
    if (startValid) begin
      blc = int'(modeWord[2:0]); clc = int'(modeWord[6:4]);
      err = (blc >= 4 && blc <= 6) || !(clc == 2 || clc == 3) || (modeWord[8:7] != 0);
      single = modeWord[9] && isWrite;
      mValid = 1; mK = 0; mBase = int'(startCol); mErr = err;
      mRow = (blc == 7) && !err && !single;
      mIlv = modeWord[3];
      if (err || single) mLen = 1;
      else if (blc == 7) mLen = 256;
      else mLen = 1 << blc;
    end else if (mValid) begin
      if (mRow && stopReq) mValid = 0;
      else if (beatEn) begin
        if (!mRow && mK == mLen - 1) mValid = 0;
        else mK = (mK + 1) % 256;
      end
    end
  endtask

  task automatic step(bit st, int col, logic [9:0] mode, bit wr, bit en, bit stp, string tag);
    string t;
    startValid = st; startCol = col[7:0]; modeWord = mode; isWrite = wr;
    beatEn = en; stopReq = stp;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    t = tag;
    if (t == "") t = mErr ? "R11" : (mRow ? "R7" : (mIlv ? "R4" : "R3"));
    check(t, colValid, mValid, "colValid");
    check(t, modeErr, mErr, "modeErr");
    check(mValid && !mRow && mK == mLen - 1 ? "R6" : t, lastBeat,
          mValid && !mRow && mK == mLen - 1, "lastBeat");
    if (mValid) check(t, colOut, expCol(mBase, mK, mLen, mIlv, mRow), "colOut");
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    logic [9:0] m;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12", colValid, 0, "colValid");
    check("R12", lastBeat, 0, "lastBeat");
    check("R12", modeErr, 0, "modeErr");
    check("R12", colOut, 0, "colOut");
    rstN = 1'b1;
    @(negedge clk);

    // R1, R2, R3: counting order length 4 from 0x2E
    m = mkMode(2, 0, 2, 0, 0);
    step(1, 8'h2E, m, 0, 0, 0, "R2");
    for (int i = 0; i < 4; i++) step(0, 0, m, 0, 1, 0, "R3");
    // R1, R4: XOR order length 8
    m = mkMode(3, 1, 3, 0, 0);
    step(1, 8'h35, m, 0, 1, 0, "R1");
    for (int i = 0; i < 8; i++) step(0, 0, m, 0, 1, 0, "R4");
    // R5: holding beats
    step(1, 8'h41, mkMode(1, 0, 2, 0, 0), 0, 0, 0, "R2");
    for (int i = 0; i < 3; i++) step(0, 0, m, 0, 0, 0, "R5");
    step(0, 0, m, 0, 1, 0, "R5");
    step(0, 0, m, 0, 0, 0, "R5");
    step(0, 0, m, 0, 1, 0, "R6");
    // R8: terminate ignored on length 2
    m = mkMode(1, 1, 2, 0, 0);
    step(1, 8'h10, m, 0, 0, 0, "R2");
    step(0, 0, m, 0, 0, 1, "R8");
    step(0, 0, m, 0, 1, 1, "R8");
    step(0, 0, m, 0, 1, 1, "R8");
    // R7: whole row from 0xFE wraps, ignores bit 3, then stops
    m = mkMode(7, 1, 3, 0, 0);
    step(1, 8'hFE, m, 0, 0, 0, "R7");
    for (int i = 0; i < 5; i++) step(0, 0, m, 0, 1, 0, "R7");
    step(0, 0, m, 0, 0, 1, "R7");
    step(0, 0, m, 0, 1, 0, "R7");
    // R9: restart mid-burst
    m = mkMode(3, 0, 2, 0, 0);
    step(1, 8'h07, m, 0, 1, 0, "R2");
    step(0, 0, m, 0, 1, 0, "R9");
    step(1, 8'hA3, m, 0, 1, 0, "R9");
    for (int i = 0; i < 8; i++) step(0, 0, m, 0, 1, 0, "R9");
    // R10: single write versus read
    m = mkMode(2, 0, 2, 0, 1);
    step(1, 8'h22, m, 1, 1, 0, "R10");
    step(0, 0, m, 0, 1, 0, "R10");
    step(1, 8'h22, m, 0, 1, 0, "R10");
    for (int i = 0; i < 4; i++) step(0, 0, m, 0, 1, 0, "R10");
    // R11: reserved length, latency and operating codes
    step(1, 8'h55, mkMode(5, 0, 2, 0, 0), 0, 1, 0, "R11");
    step(0, 0, m, 0, 1, 0, "R11");
    step(1, 8'h56, mkMode(3, 0, 4, 0, 0), 0, 1, 0, "R11");
    step(0, 0, m, 0, 1, 0, "R11");
    step(1, 8'h57, mkMode(3, 0, 3, 1, 0), 0, 0, 0, "R11");
    step(0, 0, m, 0, 1, 0, "R11");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      bit st, en, sp, wr;
      int bl, cl;
      st = ($urandom % 100) < 8;
      en = ($urandom % 100) < 70;
      sp = ($urandom % 100) < 4;
      wr = $urandom % 2;
      bl = ($urandom % 100) < 85 ? ((($urandom % 5) == 4) ? 7 : int'($urandom % 4))
                                : int'($urandom % 8);
      cl = ($urandom % 100) < 90 ? 2 + int'($urandom % 2) : int'($urandom % 8);
      m = mkMode(bl, $urandom % 2, cl, (($urandom % 100) < 5) ? 1 : 0,
                 (($urandom % 100) < 20) ? 1 : 0);
      step(st, int'($urandom % 256), m, wr, en, sp, "");
    end
    finishRun();
  end
endmodule